// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 SDRAM interface. It takes the memory from reset to a usable state. After the controller reset is released, or after a one-cycle start pulse, it holds clock-enable low while the clock settles. It then presents a no-operation command and raises clock-enable. It waits out the reset exit time and writes the four mode registers, each at its own bank address. It then starts long ZQ calibration and waits for DLL lock and calibration to complete before it raises a done flag.

Every delay is a cycle counter whose length is worked out from parameters: the memory clock period in picoseconds, the self-refresh exit time in clocks, the mode-register spacings, and the DLL-lock and calibration times. The contents of the mode registers are supplied as input words. The sequencer forces only the bits that the bring-up order needs: DLL enable in MR1 and DLL reset in MR0. Commands appear on the four active-low command strobes (chip select, row, column, write) as the nibble {select, row, column, write}. No-operation is 0111, mode-register-set is 0000 and ZQ-calibration-long is 0110.

Top module: `ddr3_powerup_seq`

## Requirements
- R1: One cycle after a clock edge that sees `start` high, and in the first cycle after `rst_n` is released, the outputs are in cycle 0 of the sequence: `mem_cke` low, command 0111, `init_done` low. Cycle counts in R2 to R9 are measured from this cycle 0.
- R2: `mem_cke` stays low for cycles 0 to LS, where LS = max(5, ceil(10000 / CLK_PS)). The command in cycle LS, the last cycle before `mem_cke` rises, is no-operation (0111). `mem_cke` is first high in cycle LS+1.
- R3: Once `mem_cke` is high, it stays high in every cycle until the next reset or start.
- R4: `mem_odt` is low in every cycle.
- R5: The first mode-register-set (0000) occurs exactly LX cycles after `mem_cke` rises, where LX = max(TXS_CYC, 5).
- R6: Exactly four mode-register-set commands are issued, each T_MRD cycles after the one before. Their bank addresses, in order, are 3'b010, 3'b011, 3'b001, 3'b000.
- R7: With bank 3'b010 the address equals `mr2_word`, and with 3'b011 it equals `mr3_word`. With 3'b001 it equals `mr1_word` with bit 0 cleared. With 3'b000 it equals `mr0_word` with bit 8 set.
- R8: ZQ-calibration-long (0110) is issued LM cycles after the last mode-register-set, where LM = max(12, ceil(15000 / CLK_PS)). Its address has bit 10 set and all other bits zero, and its bank is 3'b000.
- R9: `init_done` rises exactly LF = max(T_DLLK, T_ZQINIT) cycles after the ZQ-calibration-long cycle. It then stays high until the next reset or start.
- R10: In every cycle other than the five command cycles, the command is 0111, the bank is 3'b000 and the address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same rate as the memory command clock |
| rst_n | input | 1 | Synchronous active-low reset; releasing it begins the sequence |
| start | input | 1 | Synchronous restart pulse; restarts the sequence from cycle 0 |
| mr0_word | input | ADDR_W | Application settings for MR0 |
| mr1_word | input | ADDR_W | Application settings for MR1 |
| mr2_word | input | ADDR_W | Application settings for MR2 |
| mr3_word | input | ADDR_W | Application settings for MR3 |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_odt | output | 1 | On-die termination control, held low |
| cmd_sel_n | output | 1 | Active-low chip select strobe |
| cmd_row_n | output | 1 | Active-low row strobe |
| cmd_col_n | output | 1 | Active-low column strobe |
| cmd_wr_n | output | 1 | Active-low write strobe |
| mem_bank | output | 3 | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once initialization has completed |

## Verification
The bench checks the cycle in which each command lands: the last low cycle of clock enable, the first mode-register-set, each 4-cycle gap, the ZQ command and the exact cycle in which done rises. An off-by-one counter shifts one of these cycles and is caught there. It sets bit 0 of the MR1 word and clears bit 8 of the MR0 word. A sequencer that passed those words through unchanged would leave the DLL disabled or fail to reset it. It restarts the sequence both in the middle and after completion, and it also resets in the middle. A design that kept clock enable high across a restart, or left done latched high, would not show the cycle-0 values. Every idle cycle is watched for stray commands, bank or address bits, and for ODT ever going high.

// File: rtl/ddr3pu_pkg.sv
// Shared types and command encodings for the DDR3 power-up sequencer.
// Assumes the command nibble is ordered {select, row, column, write}, active low.
package ddr3pu_pkg;

    typedef enum logic [3:0] {
        ST_SETTLE, ST_PRECKE, ST_XPR,
        ST_MR2, ST_GAP2, ST_MR3, ST_GAP3,
        ST_MR1, ST_GAP1, ST_MR0, ST_MOD,
        ST_ZQCL, ST_FINAL, ST_READY
    } seq_state_t;

    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_MRS  = 4'b0000;
    localparam logic [3:0] CMD_ZQCL = 4'b0110;

    localparam logic [2:0] BANK_MR0 = 3'b000;
    localparam logic [2:0] BANK_MR1 = 3'b001;
    localparam logic [2:0] BANK_MR2 = 3'b010;
    localparam logic [2:0] BANK_MR3 = 3'b011;

    // Larger of two cycle counts.
    function automatic int cmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Picoseconds rounded up to whole clocks.
    function automatic int ps_to_cyc(input int ps, input int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/ddr3pu_timer.sv
// Down-counter shared by every step of the sequence.
// Loads a value on request, counts to zero and holds there.
// Assumes the load value fits in CNT_W bits.
module ddr3pu_timer #(
    parameter int              CNT_W   = 10,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/ddr3pu_fsm.sv
// Step sequencer: walks the fixed bring-up order.
// Each state lasts a number of cycles set by parameters; the shared
// timer measures them. Assumes every gap length is at least 2.
module ddr3pu_fsm
    import ddr3pu_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int L_SETTLE = 8,
    parameter int L_XPR    = 24,
    parameter int L_MRD    = 4,
    parameter int L_MOD    = 12,
    parameter int L_FINAL  = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tmr_zero,
    output seq_state_t       state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    seq_state_t nxt;
    logic       advance;

    // Successor of each step in the bring-up order.
    function automatic seq_state_t succ(input seq_state_t s);
        case (s)
            ST_SETTLE: return ST_PRECKE;
            ST_PRECKE: return ST_XPR;
            ST_XPR:    return ST_MR2;
            ST_MR2:    return ST_GAP2;
            ST_GAP2:   return ST_MR3;
            ST_MR3:    return ST_GAP3;
            ST_GAP3:   return ST_MR1;
            ST_MR1:    return ST_GAP1;
            ST_GAP1:   return ST_MR0;
            ST_MR0:    return ST_MOD;
            ST_MOD:    return ST_ZQCL;
            ST_ZQCL:   return ST_FINAL;
            default:   return ST_READY;
        endcase
    endfunction

    // Cycles spent in each step, minus one, as the timer load value.
    function automatic logic [CNT_W-1:0] hold(input seq_state_t s);
        case (s)
            ST_SETTLE:                  return CNT_W'(L_SETTLE - 1);
            ST_XPR:                     return CNT_W'(L_XPR - 1);
            ST_GAP2, ST_GAP3, ST_GAP1:  return CNT_W'(L_MRD - 2);
            ST_MOD:                     return CNT_W'(L_MOD - 2);
            ST_FINAL:                   return CNT_W'(L_FINAL - 2);
            default:                    return '0;
        endcase
    endfunction

    // Next-step and timer-load decisions.
    always_comb begin
        nxt      = succ(state);
        advance  = tmr_zero && (state != ST_READY);
        tmr_load = start || advance;
        tmr_val  = start ? hold(ST_SETTLE) : hold(nxt);
    end

    // Step register; start restarts from clock settle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_SETTLE;
        else if (start)
            state <= ST_SETTLE;
        else if (advance)
            state <= nxt;
    end

endmodule

// File: rtl/ddr3pu_cmd_enc.sv
// Pin encoder: turns the current step into CKE, ODT, command, bank and
// address values. Purely combinational from the step register.
// Assumes ADDR_W is at least 11 so that bit 10 exists.
module ddr3pu_cmd_enc
    import ddr3pu_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  seq_state_t        state,
    input  logic [ADDR_W-1:0] mr0_word,
    input  logic [ADDR_W-1:0] mr1_word,
    input  logic [ADDR_W-1:0] mr2_word,
    input  logic [ADDR_W-1:0] mr3_word,
    output logic              cke,
    output logic              odt,
    output logic [3:0]        cmd,
    output logic [2:0]        bank,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam logic [ADDR_W-1:0] DLL_EN_MASK = ~(ADDR_W'(1));
    localparam logic [ADDR_W-1:0] DLL_RST_BIT = ADDR_W'(1) << 8;
    localparam logic [ADDR_W-1:0] ZQ_LONG_BIT = ADDR_W'(1) << 10;

    // Decode the step into pin values.
    always_comb begin
        cke  = !(state inside {ST_SETTLE, ST_PRECKE});
        odt  = 1'b0;
        done = (state == ST_READY);
        cmd  = CMD_NOP;
        bank = '0;
        addr = '0;
        case (state)
            ST_MR2: begin
                cmd  = CMD_MRS;
                bank = BANK_MR2;
                addr = mr2_word;
            end
            ST_MR3: begin
                cmd  = CMD_MRS;
                bank = BANK_MR3;
                addr = mr3_word;
            end
            ST_MR1: begin
                cmd  = CMD_MRS;
                bank = BANK_MR1;
                addr = mr1_word & DLL_EN_MASK;
            end
            ST_MR0: begin
                cmd  = CMD_MRS;
                bank = BANK_MR0;
                addr = mr0_word | DLL_RST_BIT;
            end
            ST_ZQCL: begin
                cmd  = CMD_ZQCL;
                addr = ZQ_LONG_BIT;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr3_powerup_seq.sv
// Top of the DDR3 power-up sequencer. Works out every delay in clocks
// from the clock period and the timing parameters, and wires the step
// sequencer, the shared timer and the pin encoder together.
// Assumes clk is the memory command clock and CLK_PS its period.
module ddr3_powerup_seq
    import ddr3pu_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int CLK_PS   = 1250,
    parameter int TXS_CYC  = 24,
    parameter int T_MRD    = 4,
    parameter int T_DLLK   = 512,
    parameter int T_ZQINIT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] mr0_word,
    input  logic [ADDR_W-1:0] mr1_word,
    input  logic [ADDR_W-1:0] mr2_word,
    input  logic [ADDR_W-1:0] mr3_word,
    output logic              mem_cke,
    output logic              mem_odt,
    output logic              cmd_sel_n,
    output logic              cmd_row_n,
    output logic              cmd_col_n,
    output logic              cmd_wr_n,
    output logic [2:0]        mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);

    localparam int L_SETTLE = cmax(5, ps_to_cyc(10000, CLK_PS));
    localparam int L_XPR    = cmax(TXS_CYC, 5);
    localparam int L_MRD    = T_MRD;
    localparam int L_MOD    = cmax(12, ps_to_cyc(15000, CLK_PS));
    localparam int L_FINAL  = cmax(T_DLLK, T_ZQINIT);
    localparam int L_MAX    = cmax(cmax(L_SETTLE, L_XPR), cmax(L_MOD, L_FINAL));
    localparam int CNT_W    = $clog2(L_MAX + 1);

    seq_state_t       state;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [3:0]       cmd;

    ddr3pu_fsm #(
        .CNT_W   (CNT_W),
        .L_SETTLE(L_SETTLE),
        .L_XPR   (L_XPR),
        .L_MRD   (L_MRD),
        .L_MOD   (L_MOD),
        .L_FINAL (L_FINAL)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tmr_zero(tmr_zero),
        .state   (state),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val)
    );

    ddr3pu_timer #(
        .CNT_W  (CNT_W),
        .RST_VAL(CNT_W'(L_SETTLE - 1))
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    ddr3pu_cmd_enc #(
        .ADDR_W(ADDR_W)
    ) u_enc (
        .state   (state),
        .mr0_word(mr0_word),
        .mr1_word(mr1_word),
        .mr2_word(mr2_word),
        .mr3_word(mr3_word),
        .cke     (mem_cke),
        .odt     (mem_odt),
        .cmd     (cmd),
        .bank    (mem_bank),
        .addr    (mem_addr),
        .done    (init_done)
    );

    assign {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = cmd;

endmodule

// File: rtl/ddr3pu_checker.sv
// Timing and encoding properties of the power-up sequencer, observed
// at its ports. Long windows are measured with counters here rather
// than with deep delays. Bound into every ddr3_powerup_seq instance.
module ddr3pu_checker #(
    parameter int ADDR_W  = 14,
    parameter int L_XPR   = 24,
    parameter int L_FINAL = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_cke,
    input logic              cmd_sel_n,
    input logic              cmd_row_n,
    input logic              cmd_col_n,
    input logic              cmd_wr_n,
    input logic [2:0]        mem_bank,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              init_done
);

    logic [3:0]  cmd;
    logic        is_mrs;
    logic        is_zq;
    logic [15:0] cke_age;
    logic [15:0] zq_age;

    assign cmd    = {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n};
    assign is_mrs = (cmd == 4'b0000);
    assign is_zq  = (cmd == 4'b0110);

    // Cycles since clock enable rose, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !mem_cke)
            cke_age <= '0;
        else if (cke_age != 16'hFFFF)
            cke_age <= cke_age + 1'b1;
    end

    // Cycles since the calibration command, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            zq_age <= '0;
        else if (is_zq)
            zq_age <= 16'd1;
        else if (zq_age != '0 && zq_age != 16'hFFFF)
            zq_age <= zq_age + 1'b1;
    end

    a_r3_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cke && !start) |=> mem_cke);

    a_r2_nop_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cke) |-> ($past(cmd) == 4'b0111));

    a_r5_xpr_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (mem_cke && cke_age >= 16'(L_XPR)));

    a_r6_mrs_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (mem_bank[2] == 1'b0));

    a_r7_dll_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrs && mem_bank == 3'b001) |-> (mem_addr[0] == 1'b0));

    a_r7_dll_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrs && mem_bank == 3'b000) |-> mem_addr[8]);

    a_r8_zq_long: assert property (@(posedge clk) disable iff (!rst_n)
        is_zq |-> (mem_addr[10] && mem_cke));

    a_r9_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (zq_age >= 16'(L_FINAL)));

endmodule

bind ddr3_powerup_seq ddr3pu_checker #(
    .ADDR_W (ADDR_W),
    .L_XPR  (L_XPR),
    .L_FINAL(L_FINAL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mem_cke  (mem_cke),
    .cmd_sel_n(cmd_sel_n),
    .cmd_row_n(cmd_row_n),
    .cmd_col_n(cmd_col_n),
    .cmd_wr_n (cmd_wr_n),
    .mem_bank (mem_bank),
    .mem_addr (mem_addr),
    .init_done(init_done)
);

// File: tb/sim_ddr3_powerup_seq.sv
// Bench for the power-up sequencer at default parameters:
// LS=8, LX=24, T_MRD=4, LM=12, LF=512.
module sim_ddr3_powerup_seq;

    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mr0_word = 14'h0A30;
    logic [AW-1:0] mr1_word = 14'h0045;
    logic [AW-1:0] mr2_word = 14'h0018;
    logic [AW-1:0] mr3_word = 14'h0004;
    logic          mem_cke, mem_odt, cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n;
    logic [2:0]    mem_bank;
    logic [AW-1:0] mem_addr;
    logic          init_done;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int mrs_seen = 0;
    bit cke_bad = 0, odt_bad = 0, idle_bad = 0, finished = 0;

    always #10 clk = ~clk;

    ddr3_powerup_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mr0_word(mr0_word), .mr1_word(mr1_word),
        .mr2_word(mr2_word), .mr3_word(mr3_word),
        .mem_cke(mem_cke), .mem_odt(mem_odt),
        .cmd_sel_n(cmd_sel_n), .cmd_row_n(cmd_row_n),
        .cmd_col_n(cmd_col_n), .cmd_wr_n(cmd_wr_n),
        .mem_bank(mem_bank), .mem_addr(mem_addr), .init_done(init_done)
    );

    // Expected schedule: {cycle[24:9], cmd[8:5], cke[4], done[3], bank[2:0]}.
    localparam logic [24:0] VEC [16] = '{
        {16'd0,   4'b0111, 1'b0, 1'b0, 3'b000},
        {16'd7,   4'b0111, 1'b0, 1'b0, 3'b000},
        {16'd8,   4'b0111, 1'b0, 1'b0, 3'b000},
        {16'd9,   4'b0111, 1'b1, 1'b0, 3'b000},
        {16'd32,  4'b0111, 1'b1, 1'b0, 3'b000},
        {16'd33,  4'b0000, 1'b1, 1'b0, 3'b010},
        {16'd34,  4'b0111, 1'b1, 1'b0, 3'b000},
        {16'd36,  4'b0111, 1'b1, 1'b0, 3'b000},
        {16'd37,  4'b0000, 1'b1, 1'b0, 3'b011},
        {16'd41,  4'b0000, 1'b1, 1'b0, 3'b001},
        {16'd45,  4'b0000, 1'b1, 1'b0, 3'b000},
        {16'd56,  4'b0111, 1'b1, 1'b0, 3'b000},
        {16'd57,  4'b0110, 1'b1, 1'b0, 3'b000},
        {16'd58,  4'b0111, 1'b1, 1'b0, 3'b000},
        {16'd568, 4'b0111, 1'b1, 1'b0, 3'b000},
        {16'd569, 4'b0111, 1'b1, 1'b1, 3'b000}
    };

    function automatic logic [3:0] cmd_now();
        return {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n};
    endfunction

    // Address expected in a command cycle, from R7 and R8.
    function automatic logic [AW-1:0] exp_addr(input logic [3:0] c, input logic [2:0] b);
        if (c == 4'b0110) return 14'h0400;
        if (c != 4'b0000) return '0;
        case (b)
            3'b010:  return mr2_word;
            3'b011:  return mr3_word;
            3'b001:  return mr1_word & ~14'h0001;
            default: return mr0_word | 14'h0100;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Advance to cycle k, watching every cycle on the way.
    task automatic go_to(input int k);
        while (cyc < k) begin
            @(negedge clk);
            cyc++;
            if (cyc >= 9 && !mem_cke) cke_bad = 1;
            if (mem_odt) odt_bad = 1;
            if (cmd_now() == 4'b0000) mrs_seen++;
            if (!(cyc inside {33, 37, 41, 45, 57}) &&
                (cmd_now() != 4'b0111 || mem_bank != 3'b000 || mem_addr != '0))
                idle_bad = 1;
        end
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        #1;
        // R1 reset state
        chk("R1 reset cke", mem_cke, 0);
        chk("R1 reset cmd", cmd_now(), 4'b0111);
        chk("R1 reset done", init_done, 0);

        // Schedule walk (R2 R5 R6 R8 R9 R10)
        foreach (VEC[i]) begin
            go_to(int'(VEC[i][24:9]));
            chk("R2 R3 cke", mem_cke, VEC[i][4]);
            chk("R6 R8 R10 cmd", cmd_now(), VEC[i][8:5]);
            chk("R6 bank", mem_bank, VEC[i][2:0]);
            chk("R9 done", init_done, VEC[i][3]);
            chk("R7 R8 addr", mem_addr, exp_addr(VEC[i][8:5], VEC[i][2:0]));
        end
        go_to(700);
        chk("R9 done held", init_done, 1);
        chk("R3 cke never dropped", cke_bad, 0);
        chk("R4 odt never high", odt_bad, 0);
        chk("R6 four mode writes", mrs_seen, 4);
        chk("R10 idle cycles clean", idle_bad, 0);

        // Restart after completion: done must fall (R1 R9)
        do_start();
        chk("R1 restart cke low", mem_cke, 0);
        chk("R9 done cleared by start", init_done, 0);
        chk("R1 restart cmd", cmd_now(), 4'b0111);

        // Restart in the middle, after cke rose (R1 R3)
        go_to(40);
        do_start();
        chk("R1 mid restart cke", mem_cke, 0);
        mrs_seen = 0;
        go_to(32);
        chk("R5 no early mode write", mrs_seen, 0);
        go_to(33);
        chk("R5 MR2 after restart", cmd_now(), 4'b0000);
        chk("R6 MR2 bank after restart", mem_bank, 3'b010);

        // New mode words take effect on the next pass (R7)
        mr1_word = 14'h0000;
        mr0_word = 14'h3FFF;
        go_to(41);
        chk("R7 MR1 zero word", mem_addr, 14'h0000);
        go_to(45);
        chk("R7 MR0 all ones", mem_addr, 14'h3FFF);

        // Reset in the middle (R1)
        go_to(50);
        do_reset();
        chk("R1 mid reset cke", mem_cke, 0);
        chk("R1 mid reset cmd", cmd_now(), 4'b0111);
        chk("R1 mid reset done", init_done, 0);
        cke_bad = 0;
        go_to(8);
        chk("R2 cke still low at LS", mem_cke, 0);
        go_to(9);
        chk("R2 cke rises at LS+1", mem_cke, 1);

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

endmodule